// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block produces one complete flow-control pause frame as a stream of bytes each time it receives a start pulse. The frame runs from the preamble to the 32-bit frame check sequence. The only variable content is the station source address and a 16-bit pause time. Both are captured when the start pulse is accepted. Every other byte comes from fixed constants: the reserved multicast destination, the MAC control type, the pause opcode and the zero padding.

The CRC-32 is computed byte by byte as the frame covered by the check goes out, so no frame buffer is needed. The output is a byte stream with a valid/ready handshake and a last marker. A busy flag covers the whole emission, and a start pulse that arrives while busy is ignored.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, out_valid_o and out_last_o are low until a start pulse is accepted.
- R2: A start_i high while idle is accepted at the clock edge. From the next cycle busy_o and out_valid_o are high, and the stream opens with seven 55h bytes followed by one D5h byte.
- R3: The next six bytes are 01h 80h C2h 00h 00h 01h. After them comes the source address, with bits 47:40 sent first and bits 7:0 last, as captured at start acceptance.
- R4: After the source address come 88h, 08h, then 00h, 01h, then the pause time sent most significant byte first, as captured at start acceptance.
- R5: The pause time is followed by exactly 42 bytes of 00h.
- R6: The last four bytes are the FCS, sent least significant byte first, for a total of 72 bytes. The FCS is a CRC-32 over the 60 bytes from the destination address through the padding. The CRC uses reflected polynomial EDB88320h and starts from FFFFFFFFh. Each byte is processed bit 0 first, and the result is inverted.
- R7: While out_valid_o is high and out_ready_i is low, out_data_o and out_last_o hold their values and out_valid_o stays high.
- R8: out_last_o is high only while the final FCS byte is presented.
- R9: busy_o and out_valid_o fall in the cycle after the final byte is accepted. A new start pulse is accepted in that cycle.
- R10: A start pulse, or changes to src_addr_i and pause_time_i, while busy_o is high have no effect on the frame being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to emit one pause frame |
| src_addr_i | input | 48 | Station source address |
| pause_time_i | input | 16 | Pause time parameter |
| out_data_o | output | 8 | Stream byte |
| out_valid_o | output | 1 | Stream byte is valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_last_o | output | 1 | Final byte of the frame |
| busy_o | output | 1 | Frame emission in progress |

## Verification
Frames are generated for several address and pause-time values, including all-zero, all-one and mixed patterns. These values separate byte-order errors in the address and parameter fields and make any CRC bit error show in the FCS. Each frame is consumed under three ready patterns: always ready, alternating, and pseudo-random stalls. The stalls expose a counter or CRC that advances without acceptance, and a byte that changes while stalled. The inputs are changed and start is pulsed mid-frame to show that values are captured only at acceptance. Frames are issued back to back to confirm the release timing of busy.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    localparam logic [47:0] PFG_DEST_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] PFG_CTRL_TYPE = 16'h8808;
    localparam logic [15:0] PFG_OPCODE    = 16'h0001;
    localparam logic [7:0]  PFG_PRE_BYTE  = 8'h55;
    localparam logic [7:0]  PFG_SFD_BYTE  = 8'hD5;
    localparam logic [31:0] PFG_CRC_POLY  = 32'hEDB8_8320;
    localparam logic [31:0] PFG_CRC_INIT  = 32'hFFFF_FFFF;

    function automatic logic [31:0] pfg_crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (PFG_CRC_POLY & {32{r[0] ^ b[i]}});
        end
        return r;
    endfunction
endpackage

// File: rtl/pfg_crc_step.sv
module pfg_crc_step (
    input  logic [31:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);
    import pfg_pkg::*;
    always_comb begin
        crc_o = pfg_crc_byte(crc_i, byte_i);
    end
endmodule

// File: rtl/pfg_byte_mux.sv
module pfg_byte_mux #(
    parameter int unsigned PRE_LEN = 7,
    parameter int unsigned PAD_LEN = 42,
    parameter int unsigned IDX_W   = 7
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [47:0]      sa_i,
    input  logic [15:0]      prm_i,
    input  logic [31:0]      crc_i,
    output logic [7:0]       byte_o,
    output logic             crc_en_o,
    output logic             last_o
);
    import pfg_pkg::*;

    localparam int unsigned SFD_IX  = PRE_LEN;
    localparam int unsigned DA_IX   = SFD_IX + 1;
    localparam int unsigned SA_IX   = DA_IX + 6;
    localparam int unsigned TY_IX   = SA_IX + 6;
    localparam int unsigned OP_IX   = TY_IX + 2;
    localparam int unsigned PR_IX   = OP_IX + 2;
    localparam int unsigned PAD_IX  = PR_IX + 2;
    localparam int unsigned FCS_IX  = PAD_IX + PAD_LEN;
    localparam int unsigned LAST_IX = FCS_IX + 3;

    int unsigned ix;
    logic [31:0] fcs;

    always_comb begin
        ix       = {{(32-IDX_W){1'b0}}, idx_i};
        fcs      = ~crc_i;
        byte_o   = 8'h00;
        crc_en_o = 1'b0;
        if (ix < SFD_IX) begin
            byte_o = PFG_PRE_BYTE;
        end else if (ix == SFD_IX) begin
            byte_o = PFG_SFD_BYTE;
        end else if (ix < SA_IX) begin
            byte_o   = PFG_DEST_ADDR[8*(5-(ix-DA_IX)) +: 8];
            crc_en_o = 1'b1;
        end else if (ix < TY_IX) begin
            byte_o   = sa_i[8*(5-(ix-SA_IX)) +: 8];
            crc_en_o = 1'b1;
        end else if (ix < OP_IX) begin
            byte_o   = PFG_CTRL_TYPE[8*(1-(ix-TY_IX)) +: 8];
            crc_en_o = 1'b1;
        end else if (ix < PR_IX) begin
            byte_o   = PFG_OPCODE[8*(1-(ix-OP_IX)) +: 8];
            crc_en_o = 1'b1;
        end else if (ix < PAD_IX) begin
            byte_o   = prm_i[8*(1-(ix-PR_IX)) +: 8];
            crc_en_o = 1'b1;
        end else if (ix < FCS_IX) begin
            byte_o   = 8'h00;
            crc_en_o = 1'b1;
        end else if (ix <= LAST_IX) begin
            byte_o = fcs[8*(ix-FCS_IX) +: 8];
        end
        last_o = (ix == LAST_IX);
    end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
    parameter int unsigned PRE_LEN = 7,
    parameter int unsigned PAD_LEN = 42
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [47:0] src_addr_i,
    input  logic [15:0] pause_time_i,
    output logic [7:0]  out_data_o,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic        out_last_o,
    output logic        busy_o
);
    import pfg_pkg::*;

    localparam int unsigned FRAME_LEN = PRE_LEN + 1 + 18 + PAD_LEN + 4;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [31:0]      crc;
        logic [47:0]      sa;
        logic [15:0]      prm;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [7:0]  cur_byte;
    logic        crc_en;
    logic        at_last;
    logic [31:0] crc_nxt;
    logic        accept;

    pfg_byte_mux #(
        .PRE_LEN (PRE_LEN),
        .PAD_LEN (PAD_LEN),
        .IDX_W   (IDX_W)
    ) u_mux (
        .idx_i    (st_q.idx),
        .sa_i     (st_q.sa),
        .prm_i    (st_q.prm),
        .crc_i    (st_q.crc),
        .byte_o   (cur_byte),
        .crc_en_o (crc_en),
        .last_o   (at_last)
    );

    pfg_crc_step u_crc (
        .crc_i  (st_q.crc),
        .byte_i (cur_byte),
        .crc_o  (crc_nxt)
    );

    always_comb begin
        st_d   = st_q;
        accept = st_q.busy && out_ready_i;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.crc  = PFG_CRC_INIT;
                st_d.sa   = src_addr_i;
                st_d.prm  = pause_time_i;
            end
        end else if (accept) begin
            if (crc_en) begin
                st_d.crc = crc_nxt;
            end
            if (at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data_o  = cur_byte;
    assign out_valid_o = st_q.busy;
    assign out_last_o  = st_q.busy && at_last;
    assign busy_o      = st_q.busy;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       out_ready_i,
    input logic       out_valid_o,
    input logic       out_last_o,
    input logic       busy_o,
    input logic [7:0] out_data_o
);
    // R7: a stalled byte is held
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    // R9: accepted final byte releases busy
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last_o && out_ready_i) |=> !busy_o);

    // R10: busy persists until the final byte is accepted
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(out_last_o && out_ready_i)) |=> busy_o);

    // R2: a frame begins only after a start request and opens with preamble
    a_r2_begin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(start_i) && out_data_o == 8'h55 && out_valid_o));

    // R8: last only inside a frame
    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);
endmodule

bind pause_frame_gen pfg_checker u_pfg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .busy_o      (busy_o),
    .out_data_o  (out_data_o)
);

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [47:0] src_addr_i = '0;
    logic [15:0] pause_time_i = '0;
    logic [7:0]  out_data_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic        out_last_o;
    logic        busy_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    pause_frame_gen i_pause_frame_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .src_addr_i   (src_addr_i),
        .pause_time_i (pause_time_i),
        .out_data_o   (out_data_o),
        .out_valid_o  (out_valid_o),
        .out_ready_i  (out_ready_i),
        .out_last_o   (out_last_o),
        .busy_o       (busy_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        if (k < 8)  return "R2";
        if (k < 20) return "R3";
        if (k < 26) return "R4";
        if (k < 68) return "R5";
        return "R6";
    endfunction

    task automatic run_frame(input logic [47:0] sa, input logic [15:0] pt, input int mode, input bit inject);
        logic [7:0]  exp [72];
        logic [31:0] c;
        logic [7:0]  prev;
        bit          held;
        bit          rdy;
        int          k;
        int          guard;
        for (int i = 0; i < 7; i++) exp[i] = 8'h55;
        exp[7] = 8'hD5;
        exp[8] = 8'h01; exp[9] = 8'h80; exp[10] = 8'hC2;
        exp[11] = 8'h00; exp[12] = 8'h00; exp[13] = 8'h01;
        for (int i = 0; i < 6; i++) exp[14+i] = sa[47-8*i -: 8];
        exp[20] = 8'h88; exp[21] = 8'h08; exp[22] = 8'h00; exp[23] = 8'h01;
        exp[24] = pt[15:8]; exp[25] = pt[7:0];
        for (int i = 26; i < 68; i++) exp[i] = 8'h00;
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < 68; i++) begin
            for (int b = 0; b < 8; b++) begin
                if ((c[0] ^ exp[i][b]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
                else c = c >> 1;
            end
        end
        c = ~c;
        for (int i = 0; i < 4; i++) exp[68+i] = c[8*i +: 8];

        src_addr_i = sa; pause_time_i = pt; start_i = 1'b1; out_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; src_addr_i = ~sa; pause_time_i = ~pt;   // R3/R4: captured at start only
        check(busy_o && out_valid_o, "R2", {30'd0, busy_o, out_valid_o}, 32'd3);
        k = 0; guard = 0; held = 1'b0; prev = 8'h00;
        while (k < 72 && guard < 4000) begin
            guard++;
            if (mode == 0) rdy = 1'b1;
            else if (mode == 1) rdy = guard[0];
            else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rdy = lfsr[0] | lfsr[3];
            end
            start_i = (inject && k >= 20 && k < 23);   // R10: ignored while busy
            check(out_valid_o == 1'b1, "R10", {31'd0, out_valid_o}, 32'd1);
            if (held) check(out_data_o == prev, "R7", {24'd0, out_data_o}, {24'd0, prev});
            if (rdy) begin
                check(out_data_o == exp[k], tag_of(k), {24'd0, out_data_o}, {24'd0, exp[k]});
                check(out_last_o == (k == 71), "R8", {31'd0, out_last_o}, {31'd0, k == 71});
                k++;
            end else begin
                check(out_last_o == (k == 71), "R8", {31'd0, out_last_o}, {31'd0, k == 71});
            end
            held = !rdy;
            prev = out_data_o;
            out_ready_i = rdy;
            @(negedge clk);
        end
        start_i = 1'b0;
        out_ready_i = 1'b0;
        check(k == 72, "R6", k, 72);
        check(!busy_o && !out_valid_o && !out_last_o, "R9",
              {29'd0, busy_o, out_valid_o, out_last_o}, 32'd0);
    endtask

    initial begin
        #10_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3;
        check(!busy_o && !out_valid_o && !out_last_o, "R1",
              {29'd0, busy_o, out_valid_o, out_last_o}, 32'd0);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !out_valid_o && !out_last_o, "R1",
              {29'd0, busy_o, out_valid_o, out_last_o}, 32'd0);
        run_frame(48'h0011_2233_4455, 16'h1234, 0, 1'b0);
        run_frame(48'h0000_0000_0000, 16'h0000, 1, 1'b0);
        run_frame(48'hFFFF_FFFF_FFFF, 16'hFFFF, 2, 1'b1);
        run_frame(48'hA5C3_0F96_7E81, 16'h8001, 0, 1'b1);
        run_frame(48'h0123_4567_89AB, 16'hFF00, 2, 1'b0);
        run_frame(48'hDEAD_BEEF_CAFE, 16'h00FF, 1, 1'b1);
        for (int s = 0; s < 4; s++) begin
            run_frame({8'h02, 8'(s), 32'h1357_9BDF ^ 32'(s * 32'h0101_0101)}, 16'(s * 16'h3C5A), s % 3, s[0]);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule